// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Nesting Engine

This block is the per-processor part of an interrupt controller that hands interrupts out and takes them back. Each processor has its own engine. When the processor reads an acknowledge, the engine takes the identifier offered by the priority arbiter and accepts it only if that interrupt beats the processor's current running priority. On acceptance the engine links the previously running identifier behind the new one. It raises the running priority to the new interrupt's level and pulses a pending-clear strobe.

When the processor writes an end-of-interrupt, the engine removes that identifier from its nesting chain. If the identifier is the running one, its predecessor becomes running again and the predecessor's priority is restored. If it is deeper in the chain, a short walk unlinks it in place, so completions may come out of order. A level-sensitive source whose input is still high is pulsed pending again at completion.

The priority arbiter, the pending and enable storage and the register decode live outside. The engine sees them only as inputs, and its strobes go back to them.

Top module: `irq_ack_nest`

## Requirements
- R1: After reset every processor shows running identifier 1023, running priority 0x100, busy low, no acknowledge pulse and no strobes, and every chain link holds 1023 (so completing the first acknowledged interrupt returns the processor to 1023).
- R2: An acknowledge whose offered identifier is 1023 or not below NIRQ, or whose priority (8-bit, from the table slot of that identifier) is not strictly below the running priority, answers 1023 and changes no running state and pulses no clear strobe.
- R3: An accepted acknowledge answers the offered identifier one cycle after it is taken, and that identifier becomes the running identifier with its table priority as the running priority.
- R4: An accepted acknowledge pulses pend_clr for that identifier for all processors when its one-of-many bit is 1, and only for the acknowledging processor when it is 0; strobe bit index is id*NCPU+cpu.
- R5: Whenever the running identifier is 1023 the running priority is 0x100.
- R6: A completion taken while the processor's running identifier is 1023 changes nothing and pulses no strobe.
- R7: At completion of identifier id, pend_set bit id*NCPU+cpu pulses when that source is enabled, level-sensitive (edge bit 0), its input is high and its target bit id*NCPU+cpu is set.
- R8: Completing the running identifier makes its predecessor running, with the predecessor's table priority (0x100 when the predecessor is 1023).
- R9: Completing an identifier below NIRQ that is not running raises busy for one cycle per chain link examined. Starting at the running identifier, the first link that names the completed identifier is replaced by the completed identifier's own predecessor. The running identifier is unchanged.
- R10: Requests are taken only while busy is low; an acknowledge is not taken while busy is high. When a completion and an acknowledge arrive together on one processor, the completion is taken and the acknowledge is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hp_id | input | NCPU*10 | Arbiter's highest-pending identifier per processor |
| ack_req | input | NCPU | Acknowledge request per processor |
| eoi_req | input | NCPU | Completion request per processor |
| eoi_id | input | NCPU*10 | Low ten bits of the completion write data per processor |
| prio_tab | input | NIRQ*8 | Priority of each identifier |
| src_en | input | NIRQ | Source enable |
| src_edge | input | NIRQ | 1 = edge-sensitive, 0 = level-sensitive |
| src_1ofn | input | NIRQ | 1 = one-of-many handling, 0 = each processor separately |
| src_level | input | NIRQ | Current input level of each source |
| src_tgt | input | NIRQ*NCPU | Target bits, index id*NCPU+cpu |
| busy | output | NCPU | Chain walk in progress |
| ack_done | output | NCPU | Acknowledge answer valid (one cycle) |
| ack_data | output | NCPU*10 | Acknowledge answer |
| pend_clr | output | NIRQ*NCPU | Pending-clear strobes, index id*NCPU+cpu |
| pend_set | output | NIRQ*NCPU | Pending-set strobes, index id*NCPU+cpu |
| run_id | output | NCPU*10 | Running identifier per processor |
| run_prio | output | NCPU*9 | Running priority per processor |

## Verification
Two functions can meet in one cycle. The first case is a completion and an acknowledge on the same processor: the bench asserts both in one cycle and expects the completion to win, with no acknowledge pulse until the request is offered again. The second case is an acknowledge on one processor and a completion on the other for the same identifier, with one-of-many handling and a still-high level input. The bench then expects the merged strobes to carry both clear bits and the re-pend bit in the same cycle. Random runs mix both cases with out-of-order completions, and a model that walks its own chain predicts busy length, strobes and the restored running state.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
    localparam int ID_W    = 10;
    localparam int PRIO_W  = 8;
    localparam int RPRIO_W = PRIO_W + 1;
    localparam logic [ID_W-1:0]    NO_IRQ    = 10'd1023;
    localparam logic [RPRIO_W-1:0] IDLE_PRIO = 9'h100;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_st_e;
endpackage

// File: rtl/nest_cpu_engine.sv
module nest_cpu_engine
    import irq_nest_pkg::*;
#(
    parameter int NCPU    = 2,
    parameter int NIRQ    = 64,
    parameter int CPU_IDX = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ID_W-1:0]          hp_id,
    input  logic                     ack_req,
    input  logic                     eoi_req,
    input  logic [ID_W-1:0]          eoi_id,
    input  logic [NIRQ*PRIO_W-1:0]   prio_tab,
    input  logic [NIRQ-1:0]          src_en,
    input  logic [NIRQ-1:0]          src_edge,
    input  logic [NIRQ-1:0]          src_1ofn,
    input  logic [NIRQ-1:0]          src_level,
    input  logic [NIRQ-1:0]          src_tgt_me,
    output logic                     busy,
    output logic                     ack_done,
    output logic [ID_W-1:0]          ack_data,
    output logic [NIRQ*NCPU-1:0]     clr_vec,
    output logic [NIRQ-1:0]          set_vec,
    output logic [ID_W-1:0]          run_id,
    output logic [RPRIO_W-1:0]       run_prio
);
    localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;
    localparam int CW = $clog2(NIRQ + 1);
    localparam logic [ID_W-1:0] ID_LIM  = ID_W'(NIRQ);
    localparam logic [CW-1:0]   CNT_MAX = CW'(NIRQ);

    typedef struct packed {
        walk_st_e               st;
        logic [ID_W-1:0]        run_id;
        logic [RPRIO_W-1:0]     run_prio;
        logic [ID_W-1:0]        ptr;
        logic [ID_W-1:0]        tgt;
        logic [CW-1:0]          cnt;
        logic                   ack_done;
        logic [ID_W-1:0]        ack_data;
        logic [NIRQ*NCPU-1:0]   clr;
        logic [NIRQ-1:0]        set;
    } eng_t;

    eng_t            r_q, r_d;
    logic [ID_W-1:0] pred_q [NIRQ];
    logic [ID_W-1:0] pred_d [NIRQ];

    function automatic logic [RPRIO_W-1:0] prio_of(input logic [ID_W-1:0] id,
                                                   input logic [NIRQ*PRIO_W-1:0] tab);
        if (id >= ID_LIM) return IDLE_PRIO;
        return {1'b0, tab[id[IW-1:0]*PRIO_W +: PRIO_W]};
    endfunction

    logic            eoi_take, ack_take;
    logic [IW-1:0]   e_idx, h_idx, p_idx, t_idx;
    logic [ID_W-1:0] walk_nxt;

    assign eoi_take = eoi_req && (r_q.st == ST_IDLE);
    assign ack_take = ack_req && !eoi_req && (r_q.st == ST_IDLE);
    assign e_idx    = eoi_id[IW-1:0];
    assign h_idx    = hp_id[IW-1:0];
    assign p_idx    = r_q.ptr[IW-1:0];
    assign t_idx    = r_q.tgt[IW-1:0];
    assign walk_nxt = pred_q[p_idx];

    always_comb begin
        r_d          = r_q;
        pred_d       = pred_q;
        r_d.ack_done = 1'b0;
        r_d.clr      = '0;
        r_d.set      = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (eoi_take) begin
                    if (r_q.run_id != NO_IRQ && eoi_id < ID_LIM) begin
                        if (!src_edge[e_idx] && src_en[e_idx] && src_level[e_idx]
                            && src_tgt_me[e_idx]) begin
                            r_d.set[e_idx] = 1'b1;
                        end
                        if (eoi_id == r_q.run_id) begin
                            r_d.run_id   = pred_q[e_idx];
                            r_d.run_prio = prio_of(pred_q[e_idx], prio_tab);
                        end else begin
                            r_d.st  = ST_WALK;
                            r_d.ptr = r_q.run_id;
                            r_d.tgt = eoi_id;
                            r_d.cnt = '0;
                        end
                    end
                end else if (ack_take) begin
                    r_d.ack_done = 1'b1;
                    r_d.ack_data = NO_IRQ;
                    if (hp_id < ID_LIM && prio_of(hp_id, prio_tab) < r_q.run_prio) begin
                        r_d.ack_data  = hp_id;
                        pred_d[h_idx] = r_q.run_id;
                        r_d.run_id    = hp_id;
                        r_d.run_prio  = prio_of(hp_id, prio_tab);
                        for (int c = 0; c < NCPU; c++) begin
                            r_d.clr[h_idx*NCPU + c] = src_1ofn[h_idx] || (c == CPU_IDX);
                        end
                    end
                end
            end
            ST_WALK: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (walk_nxt == r_q.tgt) begin
                    pred_d[p_idx] = pred_q[t_idx];
                    r_d.st        = ST_IDLE;
                end else if (walk_nxt == NO_IRQ || r_q.cnt == CNT_MAX) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.ptr = walk_nxt;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.run_id   <= NO_IRQ;
            r_q.run_prio <= IDLE_PRIO;
            r_q.ptr      <= NO_IRQ;
            r_q.tgt      <= NO_IRQ;
            r_q.cnt      <= '0;
            r_q.ack_done <= 1'b0;
            r_q.ack_data <= NO_IRQ;
            r_q.clr      <= '0;
            r_q.set      <= '0;
            for (int i = 0; i < NIRQ; i++) pred_q[i] <= NO_IRQ;
        end else begin
            r_q    <= r_d;
            pred_q <= pred_d;
        end
    end

    assign busy     = (r_q.st == ST_WALK);
    assign ack_done = r_q.ack_done;
    assign ack_data = r_q.ack_data;
    assign clr_vec  = r_q.clr;
    assign set_vec  = r_q.set;
    assign run_id   = r_q.run_id;
    assign run_prio = r_q.run_prio;

    assert_idle_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id == NO_IRQ) |-> (run_prio == IDLE_PRIO));

    assert_ack_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done && ack_data != NO_IRQ) |-> (run_id == ack_data));

    assert_ack_clears_own_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done && ack_data != NO_IRQ) |-> clr_vec[ack_data[IW-1:0]*NCPU + CPU_IDX]);

    assert_refused_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done && ack_data == NO_IRQ) |-> (clr_vec == '0));

    assert_idle_eoi_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !busy && run_id == NO_IRQ) |=> ($stable(run_id) && set_vec == '0));

    assert_stall_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !ack_done);
endmodule

// File: rtl/pend_merge.sv
module pend_merge #(
    parameter int NCPU = 2,
    parameter int NIRQ = 64
) (
    input  logic [NCPU*NIRQ*NCPU-1:0] clr_in,
    input  logic [NCPU*NIRQ-1:0]      set_in,
    output logic [NIRQ*NCPU-1:0]      pend_clr,
    output logic [NIRQ*NCPU-1:0]      pend_set
);
    localparam int VW = NIRQ * NCPU;

    always_comb begin
        pend_clr = '0;
        pend_set = '0;
        for (int c = 0; c < NCPU; c++) begin
            pend_clr = pend_clr | clr_in[c*VW +: VW];
            for (int i = 0; i < NIRQ; i++) begin
                pend_set[i*NCPU + c] = set_in[c*NIRQ + i];
            end
        end
    end
endmodule

// File: rtl/irq_ack_nest.sv
module irq_ack_nest
    import irq_nest_pkg::*;
#(
    parameter int NCPU = 2,
    parameter int NIRQ = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCPU*ID_W-1:0]     hp_id,
    input  logic [NCPU-1:0]          ack_req,
    input  logic [NCPU-1:0]          eoi_req,
    input  logic [NCPU*ID_W-1:0]     eoi_id,
    input  logic [NIRQ*PRIO_W-1:0]   prio_tab,
    input  logic [NIRQ-1:0]          src_en,
    input  logic [NIRQ-1:0]          src_edge,
    input  logic [NIRQ-1:0]          src_1ofn,
    input  logic [NIRQ-1:0]          src_level,
    input  logic [NIRQ*NCPU-1:0]     src_tgt,
    output logic [NCPU-1:0]          busy,
    output logic [NCPU-1:0]          ack_done,
    output logic [NCPU*ID_W-1:0]     ack_data,
    output logic [NIRQ*NCPU-1:0]     pend_clr,
    output logic [NIRQ*NCPU-1:0]     pend_set,
    output logic [NCPU*ID_W-1:0]     run_id,
    output logic [NCPU*RPRIO_W-1:0]  run_prio
);
    localparam int VW = NIRQ * NCPU;

    logic [NCPU*VW-1:0]   clr_all;
    logic [NCPU*NIRQ-1:0] set_all;

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NIRQ-1:0] tgt_me;
        for (genvar i = 0; i < NIRQ; i++) begin : g_tgt
            assign tgt_me[i] = src_tgt[i*NCPU + c];
        end

        nest_cpu_engine #(.NCPU(NCPU), .NIRQ(NIRQ), .CPU_IDX(c)) u_eng (
            .clk        (clk),
            .rst_n      (rst_n),
            .hp_id      (hp_id[c*ID_W +: ID_W]),
            .ack_req    (ack_req[c]),
            .eoi_req    (eoi_req[c]),
            .eoi_id     (eoi_id[c*ID_W +: ID_W]),
            .prio_tab   (prio_tab),
            .src_en     (src_en),
            .src_edge   (src_edge),
            .src_1ofn   (src_1ofn),
            .src_level  (src_level),
            .src_tgt_me (tgt_me),
            .busy       (busy[c]),
            .ack_done   (ack_done[c]),
            .ack_data   (ack_data[c*ID_W +: ID_W]),
            .clr_vec    (clr_all[c*VW +: VW]),
            .set_vec    (set_all[c*NIRQ +: NIRQ]),
            .run_id     (run_id[c*ID_W +: ID_W]),
            .run_prio   (run_prio[c*RPRIO_W +: RPRIO_W])
        );
    end

    pend_merge #(.NCPU(NCPU), .NIRQ(NIRQ)) u_merge (
        .clr_in   (clr_all),
        .set_in   (set_all),
        .pend_clr (pend_clr),
        .pend_set (pend_set)
    );
endmodule

// File: tb/tb_irq_ack_nest.sv
module tb_irq_ack_nest;
    localparam int NC = 2;
    localparam int NI = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [19:0]   hp_id = '0;
    logic [1:0]    ack_req = '0;
    logic [1:0]    eoi_req = '0;
    logic [19:0]   eoi_id = '0;
    logic [511:0]  prio_tab;
    logic [63:0]   src_en = '0, src_edge = '0, src_1ofn = '0, src_level = '0;
    logic [127:0]  src_tgt = '0;
    logic [1:0]    busy, ack_done;
    logic [19:0]   ack_data, run_id;
    logic [127:0]  pend_clr, pend_set;
    logic [17:0]   run_prio;

    logic [7:0]    ptab [NI];
    int            total = 0;
    int            bad = 0;

    int            m_run [NC];
    int            m_rp  [NC];
    int            m_pred[NC][NI];

    always #2.5 clk = ~clk;

    always_comb for (int i = 0; i < NI; i++) prio_tab[i*8 +: 8] = ptab[i];

    irq_ack_nest #(.NCPU(NC), .NIRQ(NI)) dut (
        .clk(clk), .rst_n(rst_n), .hp_id(hp_id), .ack_req(ack_req), .eoi_req(eoi_req),
        .eoi_id(eoi_id), .prio_tab(prio_tab), .src_en(src_en), .src_edge(src_edge),
        .src_1ofn(src_1ofn), .src_level(src_level), .src_tgt(src_tgt), .busy(busy),
        .ack_done(ack_done), .ack_data(ack_data), .pend_clr(pend_clr), .pend_set(pend_set),
        .run_id(run_id), .run_prio(run_prio));

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int rp_of(input int id);
        return (id == 1023) ? 256 : int'(ptab[id]);
    endfunction

    task automatic m_reset();
        for (int c = 0; c < NC; c++) begin
            m_run[c] = 1023;
            m_rp[c]  = 256;
            for (int i = 0; i < NI; i++) m_pred[c][i] = 1023;
        end
    endtask

    task automatic m_apply(input int c, input bit a, input bit e, input int h, input int id,
                           inout logic [127:0] clr, inout logic [127:0] set,
                           output bit done, output int data, output int walk);
        done = 0; data = 1023; walk = 0;
        if (e) begin
            if (m_run[c] != 1023 && id < NI) begin
                if (!src_edge[id] && src_en[id] && src_level[id] && src_tgt[id*NC + c])
                    set[id*NC + c] = 1'b1;
                if (id == m_run[c]) begin
                    m_run[c] = m_pred[c][id];
                    m_rp[c]  = rp_of(m_run[c]);
                end else begin
                    int p = m_run[c];
                    while (1) begin
                        int nx;
                        walk++;
                        nx = m_pred[c][p];
                        if (nx == id) begin m_pred[c][p] = m_pred[c][id]; break; end
                        if (nx == 1023) break;
                        p = nx;
                    end
                end
            end
        end else if (a) begin
            done = 1;
            if (h < NI && int'(ptab[h]) < m_rp[c]) begin
                data = h;
                m_pred[c][h] = m_run[c];
                m_run[c] = h;
                m_rp[c]  = int'(ptab[h]);
                for (int k = 0; k < NC; k++)
                    if (src_1ofn[h] || k == c) clr[h*NC + k] = 1'b1;
            end
        end
    endtask

    task automatic check_run(input string tag);
        for (int c = 0; c < NC; c++) begin
            chk({tag, " R8 run_id"}, 128'(run_id[c*10 +: 10]), 128'(m_run[c]));
            chk({tag, " R5 run_prio"}, 128'(run_prio[c*9 +: 9]), 128'(m_rp[c]));
        end
    endtask

    task automatic step(input bit a0, input bit e0, input int h0, input int i0,
                        input bit a1, input bit e1, input int h1, input int i1,
                        input string tag);
        logic [127:0] xc, xs;
        bit d[NC]; int dt[NC]; int wk[NC]; int seen[NC];
        xc = '0; xs = '0;
        m_apply(0, a0, e0, h0, i0, xc, xs, d[0], dt[0], wk[0]);
        m_apply(1, a1, e1, h1, i1, xc, xs, d[1], dt[1], wk[1]);
        @(negedge clk);
        ack_req = {a1, a0}; eoi_req = {e1, e0};
        hp_id = {10'(h1), 10'(h0)}; eoi_id = {10'(i1), 10'(i0)};
        @(negedge clk);
        ack_req = '0; eoi_req = '0;
        for (int c = 0; c < NC; c++) begin
            chk({tag, " R10 ack_done"}, 128'(ack_done[c]), 128'(d[c]));
            if (d[c]) chk({tag, " R2 R3 ack_data"}, 128'(ack_data[c*10 +: 10]), 128'(dt[c]));
        end
        chk({tag, " R4 pend_clr"}, pend_clr, xc);
        chk({tag, " R7 pend_set"}, pend_set, xs);
        seen[0] = 0; seen[1] = 0;
        while (busy != 0) begin
            for (int c = 0; c < NC; c++) if (busy[c]) seen[c]++;
            @(negedge clk);
        end
        for (int c = 0; c < NC; c++) chk({tag, " R9 walk cycles"}, 128'(seen[c]), 128'(wk[c]));
        check_run(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd24680));
        for (int i = 0; i < NI; i++) ptab[i] = 8'hC0;
        ptab[5] = 8'h80; ptab[9] = 8'h40; ptab[20] = 8'h10; ptab[30] = 8'h40;
        ptab[40] = 8'h10; ptab[12] = 8'h20; ptab[7] = 8'h30;
        do_reset();

        // R1 reset state
        chk("R1 run_id", 128'(run_id), {108'd0, 10'd1023, 10'd1023});
        chk("R1 run_prio", 128'(run_prio), {110'd0, 9'h100, 9'h100});
        chk("R1 busy", 128'(busy), 128'd0);
        chk("R1 ack_done", 128'(ack_done), 128'd0);
        chk("R1 strobes", pend_clr | pend_set, 128'd0);

        // R6 completion with nothing running
        src_en[5] = 1; src_level[5] = 1; src_tgt[10] = 1;
        step(0,1,0,5, 0,0,0,0, "R6 idle eoi");
        src_en = '0; src_level = '0; src_tgt = '0;

        // R2 refused acknowledges
        step(1,0,1023,0, 0,0,0,0, "R2 hp 1023");
        step(1,0,70,0, 0,0,0,0, "R2 hp out of range");

        // R3 R4 nesting build-up, then R1 links: chain 20 -> 9 -> 5 -> 1023
        step(1,0,5,0, 0,0,0,0, "R3 ack 5");
        step(1,0,9,0, 0,0,0,0, "R3 ack 9");
        step(1,0,20,0, 0,0,0,0, "R3 ack 20");
        step(1,0,30,0, 0,0,0,0, "R2 lower prio");
        step(1,0,40,0, 0,0,0,0, "R2 equal prio");

        // R9 out-of-order completion of 5 with R10 acknowledge stalled behind the walk
        begin
            logic [127:0] xc, xs; bit dd; int dt, wk, seen;
            xc = '0; xs = '0;
            m_apply(0, 0, 1, 0, 5, xc, xs, dd, dt, wk);
            @(negedge clk); eoi_req = 2'b01; eoi_id = 20'd5;
            @(negedge clk); eoi_req = 2'b00; ack_req = 2'b01; hp_id = 20'd1023;
            chk("R10 no ack with eoi", 128'(ack_done), 128'd0);
            seen = 0;
            while (busy[0]) begin
                seen++;
                chk("R10 ack stalled while busy", 128'(ack_done[0]), 128'd0);
                @(negedge clk);
            end
            chk("R9 walk length", 128'(seen), 128'd2);
            @(negedge clk); ack_req = 2'b00;
            chk("R10 ack after walk", 128'(ack_done[0]), 128'd1);
            chk("R10 ack after walk data", 128'(ack_data[9:0]), 128'd1023);
            check_run("R9 running kept");
        end
        step(0,1,0,20, 0,0,0,0, "R8 eoi 20");
        chk("R8 restored id 9", 128'(run_id[9:0]), 128'd9);
        step(0,1,0,9, 0,0,0,0, "R8 eoi 9 skips unlinked 5");
        chk("R5 idle prio", 128'(run_prio[8:0]), 128'h100);

        // R7 re-pend of still-high level source, and none for edge source
        src_en[7] = 1; src_level[7] = 1; src_tgt[14] = 1;
        step(1,0,7,0, 0,0,0,0, "R7 ack 7");
        step(0,1,0,7, 0,0,0,0, "R7 repend level");
        src_edge[7] = 1;
        step(1,0,7,0, 0,0,0,0, "R7 ack 7 edge");
        step(0,1,0,7, 0,0,0,0, "R7 edge no repend");

        // R4 per-processor clear, then cross-processor same-cycle ack and eoi
        step(0,0,0,0, 1,0,12,0, "R4 cpu1 ack 12 own clear");
        src_1ofn[12] = 1; src_en[12] = 1; src_level[12] = 1; src_tgt[24] = 1; src_tgt[25] = 1;
        step(1,0,12,0, 0,1,0,12, "R4 R7 cross cpu same cycle");
        // R10 same-processor ack and eoi together
        step(1,1,5,12, 0,0,0,0, "R10 eoi wins");
        step(1,0,5,0, 0,0,0,0, "R10 ack retried");
        step(0,1,0,5, 0,0,0,0, "R8 back to idle");

        // random phase
        do_reset();
        for (int i = 0; i < NI; i++) ptab[i] = 8'($urandom);
        for (int n = 0; n < 600; n++) begin
            bit a[NC]; bit e[NC]; int h[NC]; int id[NC];
            src_en = {$urandom, $urandom}; src_edge = {$urandom, $urandom};
            src_1ofn = {$urandom, $urandom}; src_level = {$urandom, $urandom};
            src_tgt = {$urandom, $urandom, $urandom, $urandom};
            for (int c = 0; c < NC; c++) begin
                int sel;
                sel = int'($urandom % 5);
                a[c] = (sel == 1 || sel == 2 || sel == 4);
                e[c] = (sel == 3 || sel == 4);
                h[c] = ($urandom % 8 == 0) ? 1023 : int'($urandom % 72);
                case ($urandom % 4)
                    0: id[c] = m_run[c];
                    1: id[c] = (m_run[c] == 1023) ? 1023 : m_pred[c][m_run[c]];
                    2: id[c] = int'($urandom % 80);
                    default: id[c] = 1023;
                endcase
            end
            step(a[0], e[0], h[0], id[0], a[1], e[1], h[1], id[1], "random R2 R3 R9");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule